// File: doc/BRIEF.md
# Reordering Stream Assembly FIFO

This block rebuilds an in-order data stream from words that a producer writes at explicit addresses, possibly out of sequence, on one clock. A consumer on a second, unrelated clock sees a plain stream: a data word, a valid flag and a consume strobe. No addresses appear on that side. The stream starts at address zero and moves up one address per consumed word. It halts in front of the lowest address whose word has not arrived yet. Addresses wrap, so the sequence never has to end.

The producer learns how far it may run ahead from `wr_base`, which is the consumer position carried into the write clock domain. A write is legal only if its address, taken relative to `wr_base` and modulo the address space, falls inside a window of 2**(AW-GW) slots. An illegal write raises a sticky failure flag. While that flag is up, the block drops every further write. The producer waits for `wr_base` to read zero after reset before its first write. A pending word that has not been consumed may be written again at the same address. The newer data then replaces the older.

Top module: `reorder_asm_fifo`

## Requirements
- R1: After both resets, `rd_valid` is 0, `wr_fail` is 0 and `wr_base` is 0.
- R2: The stream presents words in increasing address order starting at address 0. Each `rd_data` is the word last written at the address the stream has reached.
- R3: When the word at the current stream address has not been written, `rd_valid` stays 0 and no later word is shown. The stream resumes once that word arrives.
- R4: `rd_take` high in a cycle with `rd_valid` high consumes exactly one word. `rd_take` has no effect while `rd_valid` is 0. Without `rd_take`, a shown word stays valid and unchanged.
- R5: Addresses are taken modulo 2**AW, so the stream continues across the wrap from address 2**AW-1 to address 0.
- R6: A put is legal exactly when ((wr_addr - wr_base) mod 2**AW) < 2**(AW-GW). For the defaults AW=6 and GW=2, this means base+15 is accepted, while base+16 and base-1 both raise `wr_fail`.
- R7: An illegal put sets `wr_fail` on the next write-clock edge. `wr_fail` then stays at 1 until a write-side reset.
- R8: While `wr_fail` is 1, puts store nothing, and an address written in that state never reaches the stream.
- R9: Rewriting a pending, unconsumed in-window address does not set `wr_fail`. The stream then shows the newer data.
- R10: `wr_base` never runs ahead of the number of consumed words (mod 2**AW) and trails it by at most a few write cycles. Once reading stops, it equals that number. The consumer pointer crossing into the write domain changes by one code bit per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_addr | input | AW | Address of the word being put |
| wr_data | input | DW | Word being put |
| wr_put | input | 1 | Put strobe |
| wr_base | output | AW | Lowest address of the legal write window |
| wr_fail | output | 1 | Sticky flag for an illegal put |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_data | output | DW | Word at the current stream position |
| rd_valid | output | 1 | `rd_data` holds a written word |
| rd_take | input | 1 | Consume strobe |

## Verification
The bench opens a gap in the address sequence and checks that the stream halts at the gap. A design that ignored slot state would show stale memory contents there, and one that tracked the wrong lap would let through a word from the previous trip around the buffer. The bench holds `rd_take` high while no word is pending, which catches a design that advances its pointer on an empty slot and skips an address. It drives the stream across several address wraps, writing reversed groups of four words, and a wrong lap bit or modulo error would corrupt the order at the wrap. It also puts at base+15, base+16 and base-1, which exposes an off-by-one in the window compare. Finally, it writes an in-window address while failed, which catches a design that keeps storing data after the failure.

// File: rtl/raf_pkg.sv
package raf_pkg;

    // Depth of the synchronizer chains between the two clock domains.
    localparam int unsigned SYNC_STAGES = 2;

    // Number of storage slots for a given address width and guard width.
    function automatic int unsigned win_slots(input int unsigned aw, input int unsigned gw);
        return 32'd1 << (aw - gw);
    endfunction

endpackage

// File: rtl/raf_sync.sv
module raf_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/raf_slot_ram.sv
module raf_slot_ram #(
    parameter int unsigned DW = 8,
    parameter int unsigned LW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 32'd1 << LW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // The read port needs no clock: a slot is only shown after its lap marker
    // has crossed the synchronizer, long after the word has settled.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/raf_write_side.sv
module raf_write_side
    import raf_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned GW = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        put,
    input  logic [AW-1:0]               addr,
    input  logic [AW-1:0]               base_gray,
    output logic [AW-1:0]               base,
    output logic                        fail,
    output logic                        accept,
    output logic [win_slots(AW,GW)-1:0] lap
);

    localparam int unsigned LW    = AW - GW;
    localparam int unsigned DEPTH = win_slots(AW, GW);

    typedef struct packed {
        logic             fail;
        logic [AW-1:0]    base;
        logic [DEPTH-1:0] lap;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [AW-1:0] base_bin;
    logic [AW-1:0] offset;
    logic          in_win;

    always_comb begin
        st_d = st_q;

        // Decode the synchronized Gray pointer of the read side.
        base_bin[AW-1] = base_gray[AW-1];
        for (int i = int'(AW) - 2; i >= 0; i--) begin
            base_bin[i] = base_bin[i+1] ^ base_gray[i];
        end
        st_d.base = base_bin;

        // Window test against the base value the producer currently sees.
        offset = addr - st_q.base;
        in_win = (offset[AW-1 -: GW] == '0);
        accept = put && !st_q.fail && in_win;

        if (put && !st_q.fail && !in_win) begin
            st_d.fail = 1'b1;
        end

        // The lap marker records which trip around the buffer the slot holds.
        if (accept) begin
            st_d.lap[addr[LW-1:0]] = addr[LW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fail <= 1'b0;
            st_q.base <= '0;
            st_q.lap  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign base = st_q.base;
    assign fail = st_q.fail;
    assign lap  = st_q.lap;

endmodule

// File: rtl/raf_read_side.sv
module raf_read_side
    import raf_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned GW = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        take,
    input  logic [win_slots(AW,GW)-1:0] lap_seen,
    output logic                        valid,
    output logic [AW-GW-1:0]            slot,
    output logic [AW-1:0]               ptr_gray
);

    localparam int unsigned LW = AW - GW;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] gray;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      valid_c;

    always_comb begin
        st_d    = st_q;
        // A slot holds the current address when its lap matches the pointer's.
        valid_c = (lap_seen[st_q.ptr[LW-1:0]] == st_q.ptr[LW]);
        if (take && valid_c) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ptr  <= '0;
            st_q.gray <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid    = valid_c;
    assign slot     = st_q.ptr[LW-1:0];
    assign ptr_gray = st_q.gray;

endmodule

// File: rtl/reorder_asm_fifo.sv
module reorder_asm_fifo
    import raf_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 6,
    parameter int unsigned GW = 2
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_put,
    output logic [AW-1:0] wr_base,
    output logic          wr_fail,
    input  logic          rd_clk,
    input  logic          rd_rst,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          rd_take
);

    localparam int unsigned LW    = AW - GW;
    localparam int unsigned DEPTH = win_slots(AW, GW);

    logic             ram_we;
    logic [DEPTH-1:0] lap_wr;
    logic [DEPTH-1:0] lap_rd;
    logic [LW-1:0]    rd_slot;
    logic [AW-1:0]    rd_ptr_gray;
    logic [AW-1:0]    base_gray_wr;

    raf_sync #(
        .W       (AW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({AW{1'b0}})
    ) ptr_sync_i (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_ptr_gray),
        .q   (base_gray_wr)
    );

    raf_sync #(
        .W       (DEPTH),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({DEPTH{1'b1}})
    ) lap_sync_i (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (lap_wr),
        .q   (lap_rd)
    );

    raf_write_side #(
        .AW (AW),
        .GW (GW)
    ) wside_i (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .put       (wr_put),
        .addr      (wr_addr),
        .base_gray (base_gray_wr),
        .base      (wr_base),
        .fail      (wr_fail),
        .accept    (ram_we),
        .lap       (lap_wr)
    );

    raf_slot_ram #(
        .DW (DW),
        .LW (LW)
    ) ram_i (
        .wclk  (wr_clk),
        .we    (ram_we),
        .waddr (wr_addr[LW-1:0]),
        .wdata (wr_data),
        .raddr (rd_slot),
        .rdata (rd_data)
    );

    raf_read_side #(
        .AW (AW),
        .GW (GW)
    ) rside_i (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .take     (rd_take),
        .lap_seen (lap_rd),
        .valid    (rd_valid),
        .slot     (rd_slot),
        .ptr_gray (rd_ptr_gray)
    );

endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
    parameter int unsigned AW = 6
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_put,
    input logic          wr_fail,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_valid,
    input logic          rd_take,
    input logic [AW-1:0] rd_gray
);

    p_fail_sticky_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_fail |=> wr_fail);

    p_fail_cause_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(wr_fail) |-> $past(wr_put));

    p_valid_hold_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !rd_take) |=> rd_valid);

    p_ptr_still_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_valid && rd_take) |=> $stable(rd_gray));

    p_gray_step_r10: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && rd_take) |=> ($countones(rd_gray ^ $past(rd_gray)) == 1));

endmodule

bind reorder_asm_fifo raf_checker #(.AW(AW)) chk_i (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_put   (wr_put),
    .wr_fail  (wr_fail),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_valid (rd_valid),
    .rd_take  (rd_take),
    .rd_gray  (rd_ptr_gray)
);

// File: tb/reorder_asm_fifo_tb_top.sv
module reorder_asm_fifo_tb_top;

    localparam int DW   = 8;
    localparam int AW   = 6;
    localparam int GW   = 2;
    localparam int SPAN = 1 << AW;
    localparam int WIN  = 1 << (AW - GW);

    logic          wr_clk  = 1'b0;
    logic          rd_clk  = 1'b0;
    logic          wr_rst  = 1'b1;
    logic          rd_rst  = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_put  = 1'b0;
    logic          rd_take = 1'b0;
    logic [AW-1:0] wr_base;
    logic          wr_fail;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    reorder_asm_fifo #(.DW(DW), .AW(AW), .GW(GW)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_put   (wr_put),
        .wr_base  (wr_base),
        .wr_fail  (wr_fail),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_take  (rd_take)
    );

    // 50 MHz on both sides, read clock shifted by 7 ns.
    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    // Reference model state
    int          n_checks = 0;
    int          n_err    = 0;
    int          taken    = 0;
    bit          fail_exp = 1'b0;
    bit          wrote [SPAN];
    logic [DW-1:0] mem_m [SPAN];
    logic [AW-1:0] base_seen = '0;
    bit          take_en  = 1'b0;
    bit          valid_seen = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int modspan(input int v);
        return ((v % SPAN) + SPAN) % SPAN;
    endfunction

    // Write-side model: window test against the base seen before the edge.
    always @(posedge wr_clk) begin
        if (wr_rst) begin
            fail_exp = 1'b0;
            for (int i = 0; i < SPAN; i++) wrote[i] = 1'b0;
        end else if (wr_put && !fail_exp) begin
            if (modspan(int'(wr_addr) - int'(base_seen)) < WIN) begin
                wrote[wr_addr] = 1'b1;
                mem_m[wr_addr] = wr_data;
            end else begin
                fail_exp = 1'b1;
            end
        end
    end

    // Write-side comparison on every clock.
    always @(negedge wr_clk) begin
        base_seen = wr_base;
        if (!wr_rst && !rd_rst) begin
            chk(wr_fail == fail_exp, "R7", int'(wr_fail), int'(fail_exp));
            chk(modspan(taken - int'(wr_base)) <= 6, "R10", int'(wr_base), modspan(taken));
        end
    end

    // Read-side model and comparison on every clock.
    always @(negedge rd_clk) begin
        rd_take = take_en;
        valid_seen = rd_valid;
        if (!rd_rst && rd_valid) begin
            chk(wrote[modspan(taken)] && rd_data == mem_m[modspan(taken)], "R2",
                int'(rd_data), int'(mem_m[modspan(taken)]));
        end
    end

    always @(posedge rd_clk) begin
        if (rd_rst) begin
            taken = 0;
        end else if (rd_take && valid_seen) begin
            wrote[modspan(taken)] = 1'b0;
            taken++;
        end
    end

    task automatic put_word(input int a, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_put  = 1'b1;
        wr_addr = AW'(modspan(a));
        wr_data = d;
        @(negedge wr_clk);
        wr_put  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic wait_drain(input int target, input string req);
        for (int k = 0; k < 300; k++) begin
            if (taken == target) break;
            @(negedge wr_clk);
        end
        chk(taken == target, req, taken, target);
    endtask

    task automatic wait_window(input int a);
        for (int k = 0; k < 300; k++) begin
            if (modspan(a - int'(wr_base)) < WIN) break;
            @(negedge wr_clk);
        end
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        wr_rst  = 1'b1;
        rd_rst  = 1'b1;
        take_en = 1'b0;
        idle(4);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        idle(2);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R2: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        idle(5);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        idle(2);
        // R1: reset state
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        chk(wr_fail == 1'b0, "R1", int'(wr_fail), 0);
        chk(wr_base == '0, "R1", int'(wr_base), 0);

        // R2: in-order stream from address 0
        take_en = 1'b1;
        for (int a = 0; a < 8; a++) put_word(a, pat(a));
        wait_drain(8, "R2");

        // R3: gap at address 10 halts the stream
        put_word(8, pat(8));
        put_word(9, pat(9));
        put_word(11, pat(11));
        put_word(12, pat(12));
        idle(20);
        chk(taken == 10, "R3", taken, 10);
        chk(rd_valid == 1'b0, "R3", int'(rd_valid), 0);
        put_word(10, pat(10));
        wait_drain(13, "R3");

        // R4: held word stays valid and unchanged without rd_take
        take_en = 1'b0;
        put_word(13, pat(13));
        idle(10);
        chk(rd_valid == 1'b1, "R4", int'(rd_valid), 1);
        chk(rd_data == pat(13), "R4", int'(rd_data), int'(pat(13)));
        idle(6);
        chk(rd_valid == 1'b1 && rd_data == pat(13), "R4", int'(rd_data), int'(pat(13)));
        chk(taken == 13, "R4", taken, 13);
        take_en = 1'b1;
        wait_drain(14, "R4");

        // R4: rd_take held while nothing is pending must not skip
        idle(12);
        chk(taken == 14, "R4", taken, 14);
        put_word(14, pat(14));
        wait_drain(15, "R4");
        put_word(15, pat(15));
        wait_drain(16, "R4");

        // R9: rewrite of a pending word
        take_en = 1'b0;
        put_word(16, 8'hA5);
        put_word(16, 8'h5A);
        idle(10);
        chk(wr_fail == 1'b0, "R9", int'(wr_fail), 0);
        chk(rd_data == 8'h5A, "R9", int'(rd_data), 'h5A);
        take_en = 1'b1;
        wait_drain(17, "R9");

        // R6: last legal address of the window
        take_en = 1'b0;
        idle(10);
        chk(wr_base == AW'(17), "R10", int'(wr_base), 17);
        put_word(17 + WIN - 1, pat(32));
        chk(wr_fail == 1'b0, "R6", int'(wr_fail), 0);
        for (int a = 31; a >= 17; a--) put_word(a, pat(a));
        take_en = 1'b1;
        wait_drain(33, "R6");

        // R5: reversed groups of four across several address wraps
        for (int g = 33; g < 153; g += 4) begin
            wait_window(g + 3);
            for (int j = 3; j >= 0; j--) put_word(g + j, pat(g + j));
        end
        wait_drain(153, "R5");

        // R10: base settles to the consumed count
        take_en = 1'b0;
        idle(10);
        chk(wr_base == AW'(153 % SPAN), "R10", int'(wr_base), 153 % SPAN);

        // R6/R7: first illegal address above the window
        put_word(153 + WIN, pat(0));
        chk(wr_fail == 1'b1, "R6", int'(wr_fail), 1);
        // R8: in-window put after failure is dropped
        put_word(153, pat(153));
        idle(15);
        chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);
        chk(wr_fail == 1'b1, "R7", int'(wr_fail), 1);

        // R7: only the write-side reset clears the flag
        do_reset();
        chk(wr_fail == 1'b0, "R7", int'(wr_fail), 0);
        chk(wr_base == '0, "R1", int'(wr_base), 0);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);

        // R6: address just below base is illegal
        put_word(SPAN - 1, pat(1));
        chk(wr_fail == 1'b1, "R6", int'(wr_fail), 1);
        put_word(0, pat(2));
        idle(15);
        chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);

        do_reset();
        done = 1'b1;
        finish_run();
    end

endmodule